// File: doc/BRIEF.md
# Pre-Indexed Indirect Address Sequencer

This block drives the bus, one access per clock, for the pre-indexed indirect addressing mode of an 8-bit processor, written (zp,X). The opcode and the zero-page operand byte have already been fetched when the core pulses `start`. The block then makes a discarded read at the operand's zero-page location. Next it adds X to the operand, with wrap inside page zero, to form a pointer. It reads the two pointer bytes and finally accesses the 16-bit effective address that those bytes form.

Three access kinds are supported. A load reads the effective address once. A store writes a value captured at start. A read-modify-write reads the location, writes the same value back unchanged, and then writes the result that the ALU returns. Opcode decoding and the ALU are outside the block. The sequencer marks with a strobe the cycle in which the fetched operand sits on `rd_data`, and it takes the modified value from `alu_res`. Every output is registered, and each bus cycle's address, direction and data appear together.

Top module: `zpxi_seq`

## Requirements
- R1: In the first cycle after `start` is accepted, the bus reads `{8'h00, operand}` with `we` low. The data read is not used.
- R2: In the second cycle the bus reads the pointer low byte at `{8'h00, (operand + x_val) mod 256}`.
- R3: In the third cycle the bus reads the pointer high byte at `{8'h00, (pointer + 1) mod 256}`. A pointer of 8'hFF takes its high byte from 8'h00.
- R4: For kind 0 (load), and for the spare code 3, the fourth cycle reads the effective address `{high, low}` with `ld_stb` high and `we` low. This is the last cycle.
- R5: For kind 1 (store), the fourth cycle writes the `store_val` captured at start to the effective address, with `we` high and `ld_stb` low. This is the last cycle.
- R6: For kind 2 (read-modify-write), the fourth cycle reads the effective address with `ld_stb` high. The fifth cycle writes the value just read back to the same address. The sixth cycle writes the `alu_res` value present during the fifth cycle.
- R7: `irq_sample` pulses for exactly one cycle per sequence. For load and store it falls in the fourth cycle, and for read-modify-write in the fifth cycle, after the dummy write-back and before the final write.
- R8: `done` is high only in the last cycle: the fourth for load and store, the sixth for read-modify-write. `we` is high only in the write cycles described above.
- R9: `start` is ignored while a sequence is running. When idle, `we`, `ld_stb`, `irq_sample` and `done` are low.
- R10: Synchronous reset returns the block to idle with `addr` at 0 and all strobes low, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| kind | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 treated as load |
| operand | input | 8 | Zero-page operand byte |
| x_val | input | 8 | Index register X |
| rd_data | input | 8 | Bus read data for the current cycle |
| store_val | input | 8 | Value to store, captured at start |
| alu_res | input | 8 | Modified value, sampled during the write-back cycle |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| we | output | 1 | 1 = write, 0 = read |
| irq_sample | output | 1 | Interrupt sample point |
| ld_stb | output | 1 | `rd_data` carries the operand this cycle |
| done | output | 1 | Last cycle of the sequence |

## Verification
The bench aims at two pointer wraps in page zero: an operand plus X that passes 8'hFF, and a pointer of 8'hFF whose high byte must come from 8'h00. A design that carried into page one would put the wrong address on the bus in the second or third cycle. For read-modify-write, the bench changes `alu_res` outside the write-back cycle. It also checks the unmodified write-back, so a design that skipped the dummy write or sampled the ALU late would write the wrong value. The bench also holds `start` high through a sequence, alters `operand` and `store_val` after start, and applies reset mid-sequence. These catch a design that restarts, fails to latch its inputs, or does not return to idle.

// File: rtl/zpxi_pkg.sv
package zpxi_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_RMW   = 2'd2,
    KIND_SPARE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DUMMY,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_EFF,
    ST_WBACK,
    ST_FINAL
  } step_e;
endpackage

// File: rtl/zpxi_ptr.sv
module zpxi_ptr #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   operand,
  input  logic [DATA_W-1:0]   x_val,
  input  logic [DATA_W-1:0]   ptr_q,
  output logic [DATA_W-1:0]   ptr_first,
  output logic [2*DATA_W-1:0] zp_operand,
  output logic [2*DATA_W-1:0] zp_ptr,
  output logic [2*DATA_W-1:0] zp_ptr_next
);
  localparam int ADDR_W = 2 * DATA_W;
  logic [DATA_W-1:0] ptr_inc;

  always_comb begin
    ptr_first   = operand + x_val;
    ptr_inc     = ptr_q + DATA_W'(1);
    zp_operand  = ADDR_W'(operand);
    zp_ptr      = ADDR_W'(ptr_q);
    zp_ptr_next = ADDR_W'(ptr_inc);
  end
endmodule

// File: rtl/zpxi_ctrl.sv
module zpxi_ctrl
  import zpxi_pkg::*;
(
  input  step_e state_q,
  input  logic  start,
  input  kind_e kind_q,
  output step_e state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_DUMMY;
      ST_DUMMY:  state_d = ST_PTR_LO;
      ST_PTR_LO: state_d = ST_PTR_HI;
      ST_PTR_HI: state_d = ST_EFF;
      ST_EFF:    state_d = (kind_q == KIND_RMW) ? ST_WBACK : ST_IDLE;
      ST_WBACK:  state_d = ST_FINAL;
      ST_FINAL:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/zpxi_seq.sv
module zpxi_seq
  import zpxi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            kind,
  input  logic [DATA_W-1:0]     operand,
  input  logic [DATA_W-1:0]     x_val,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [DATA_W-1:0]     store_val,
  input  logic [DATA_W-1:0]     alu_res,
  output logic [2*DATA_W-1:0]   addr,
  output logic [DATA_W-1:0]     wdata,
  output logic                  we,
  output logic                  irq_sample,
  output logic                  ld_stb,
  output logic                  done
);
  localparam int ADDR_W = 2 * DATA_W;

  step_e             state_q, state_d;
  kind_e             kind_q, kind_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [DATA_W-1:0] st_q, st_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              we_d, irq_d, ld_d, done_d;

  logic [DATA_W-1:0] ptr_first;
  logic [ADDR_W-1:0] zp_operand, zp_ptr, zp_ptr_next;

  zpxi_ptr #(.DATA_W(DATA_W)) u_ptr (
    .operand    (operand),
    .x_val      (x_val),
    .ptr_q      (ptr_q),
    .ptr_first  (ptr_first),
    .zp_operand (zp_operand),
    .zp_ptr     (zp_ptr),
    .zp_ptr_next(zp_ptr_next)
  );

  zpxi_ctrl u_ctrl (
    .state_q(state_q),
    .start  (start),
    .kind_q (kind_q),
    .state_d(state_d)
  );

  always_comb begin
    addr_d  = addr;
    wdata_d = wdata;
    we_d    = 1'b0;
    irq_d   = 1'b0;
    ld_d    = 1'b0;
    done_d  = 1'b0;
    ptr_d   = ptr_q;
    lo_d    = lo_q;
    st_d    = st_q;
    kind_d  = kind_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          addr_d = zp_operand;
          ptr_d  = ptr_first;
          st_d   = store_val;
          kind_d = kind_e'(kind);
        end
      end
      ST_DUMMY:  addr_d = zp_ptr;
      ST_PTR_LO: begin
        lo_d   = rd_data;
        addr_d = zp_ptr_next;
      end
      ST_PTR_HI: begin
        addr_d = {rd_data, lo_q};
        if (kind_q == KIND_STORE) begin
          we_d    = 1'b1;
          wdata_d = st_q;
        end else begin
          ld_d = 1'b1;
        end
        irq_d  = (kind_q != KIND_RMW);
        done_d = (kind_q != KIND_RMW);
      end
      ST_EFF: begin
        if (kind_q == KIND_RMW) begin
          we_d    = 1'b1;
          wdata_d = rd_data;
          irq_d   = 1'b1;
        end
      end
      ST_WBACK: begin
        we_d    = 1'b1;
        wdata_d = alu_res;
        done_d  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      kind_q     <= KIND_LOAD;
      ptr_q      <= '0;
      lo_q       <= '0;
      st_q       <= '0;
      addr       <= '0;
      wdata      <= '0;
      we         <= 1'b0;
      irq_sample <= 1'b0;
      ld_stb     <= 1'b0;
      done       <= 1'b0;
    end else begin
      state_q    <= state_d;
      kind_q     <= kind_d;
      ptr_q      <= ptr_d;
      lo_q       <= lo_d;
      st_q       <= st_d;
      addr       <= addr_d;
      wdata      <= wdata_d;
      we         <= we_d;
      irq_sample <= irq_d;
      ld_stb     <= ld_d;
      done       <= done_d;
    end
  end
endmodule

// File: rtl/zpxi_chk.sv
module zpxi_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [DATA_W-1:0]   operand,
  input logic [DATA_W-1:0]   rd_data,
  input logic [2*DATA_W-1:0] addr,
  input logic [DATA_W-1:0]   wdata,
  input logic                we,
  input logic                irq_sample,
  input logic                ld_stb,
  input logic                done
);
  logic [2:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc == 3'd0) cyc <= start ? 3'd1 : 3'd0;
    else if (done) cyc <= '0;
    else cyc <= cyc + 3'd1;
  end

  assert_dummy_read_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0 && start) |=> (addr == {{DATA_W{1'b0}}, $past(operand)} && !we && !ld_stb));

  assert_ptr_lo_zp_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd2) |-> (addr[2*DATA_W-1:DATA_W] == '0 && !we));

  assert_ptr_hi_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd3) |-> (addr[2*DATA_W-1:DATA_W] == '0 &&
                       addr[DATA_W-1:0] == DATA_W'($past(addr[DATA_W-1:0]) + 1'b1) && !we));

  assert_writeback_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd5) |-> (we && addr == $past(addr) && wdata == $past(rd_data)));

  assert_irq_point_R7: assert property (@(posedge clk) disable iff (rst)
    irq_sample |-> (cyc == 3'd5 || (cyc == 3'd4 && done)));

  assert_done_len_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == 3'd4 || cyc == 3'd6));

  assert_cyc_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cyc <= 3'd6);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0) |-> (!we && !done && !ld_stb && !irq_sample));
endmodule

bind zpxi_seq zpxi_chk #(.DATA_W(DATA_W)) u_zpxi_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .operand   (operand),
  .rd_data   (rd_data),
  .addr      (addr),
  .wdata     (wdata),
  .we        (we),
  .irq_sample(irq_sample),
  .ld_stb    (ld_stb),
  .done      (done)
);

// File: tb/test_zpxi_seq.sv
module test_zpxi_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [7:0]  operand = 8'h00, x_val = 8'h00, store_val = 8'h00, alu_res = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        we, irq_sample, ld_stb, done;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] zp [256];

  always #5 clk = ~clk;

  zpxi_seq i_zpxi_seq (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .operand(operand),
    .x_val(x_val), .rd_data(rd_data), .store_val(store_val), .alu_res(alu_res),
    .addr(addr), .wdata(wdata), .we(we), .irq_sample(irq_sample),
    .ld_stb(ld_stb), .done(done)
  );

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    if (a[15:8] == 8'h00) return zp[a[7:0]];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb rd_data = mem_at(addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packed view: {addr, wdata(if we), we, ld, irq, done}
  function automatic logic [27:0] pack(input logic [15:0] a, input logic [7:0] d,
                                       input logic w, input logic l, input logic i, input logic dn);
    return {a, (w ? d : 8'h00), w, l, i, dn};
  endfunction

  task automatic run_op(input logic [1:0] k, input logic [7:0] op, input logic [7:0] xv,
                        input logic [7:0] sv, input logic [7:0] av, input bit hold);
    logic [7:0]  ptr, lo, hi, orig;
    logic [15:0] ea;
    logic [27:0] exp_v, act_v;
    int n;
    string req;
    ptr  = op + xv;
    lo   = zp[ptr];
    hi   = zp[8'(ptr + 8'd1)];
    ea   = {hi, lo};
    orig = mem_at(ea);
    n    = (k == 2'd2) ? 6 : 4;
    @(negedge clk);
    start = 1'b1; kind = k; operand = op; x_val = xv; store_val = sv; alu_res = ~av;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      operand = ~op; x_val = ~xv; store_val = ~sv;
      case (c)
        1: begin exp_v = pack({8'h00, op}, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); req = "R1 dummy read"; end
        2: begin exp_v = pack({8'h00, ptr}, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); req = "R2 pointer low"; end
        3: begin exp_v = pack({8'h00, 8'(ptr + 8'd1)}, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); req = "R3 pointer high"; end
        4: begin
          exp_v = pack(ea, sv, k == 2'd1, k != 2'd1, k != 2'd2, k != 2'd2);
          req = (k == 2'd1) ? "R5 store cycle" : (k == 2'd2) ? "R6 rmw read" : "R4 load cycle";
        end
        5: begin exp_v = pack(ea, orig, 1'b1, 1'b0, 1'b1, 1'b0); req = "R6 R7 write-back"; alu_res = av; end
        default: begin exp_v = pack(ea, av, 1'b1, 1'b0, 1'b0, 1'b1); req = "R6 R8 final write"; alu_res = ~av; end
      endcase
      act_v = pack(addr, wdata, we, ld_stb, irq_sample, done);
      chk(act_v == exp_v, req, 32'(act_v), 32'(exp_v));
    end
    @(negedge clk);
    act_v = pack(addr, wdata, we, ld_stb, irq_sample, done);
    chk(we == 1'b0 && ld_stb == 1'b0 && irq_sample == 1'b0 && done == 1'b0,
        hold ? "R9 start ignored while busy" : "R8 R9 idle after done",
        32'({we, ld_stb, irq_sample, done}), 32'h0);
    start = 1'b0;
  endtask

  // {kind, operand, x, store, alu}
  localparam logic [39:0] VEC [8] = '{
    {8'd0, 8'h20, 8'h05, 8'h00, 8'h00},
    {8'd1, 8'h40, 8'h10, 8'h5C, 8'h00},
    {8'd2, 8'h80, 8'h03, 8'h00, 8'h3E},
    {8'd0, 8'hF0, 8'h0F, 8'h00, 8'h00},  // pointer FF: R3 wrap
    {8'd0, 8'hFE, 8'h03, 8'h00, 8'h00},  // operand + X passes FF: R2 wrap
    {8'd3, 8'h11, 8'h00, 8'h00, 8'h00},  // spare code acts as load: R4
    {8'd2, 8'hFF, 8'h00, 8'h00, 8'hC7},  // rmw with wrap
    {8'd1, 8'h00, 8'hFF, 8'hE1, 8'h00}
  };

  initial begin
    for (int i = 0; i < 256; i++) zp[i] = 8'(i * 13 + 7);
    repeat (3) @(negedge clk);
    chk(addr == 16'h0 && !we && !done && !ld_stb && !irq_sample, "R10 reset state",
        32'({addr, we, done, ld_stb, irq_sample}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!we && !done && !ld_stb && !irq_sample, "R9 idle quiet",
        32'({we, done, ld_stb, irq_sample}), 32'h0);

    for (int v = 0; v < 8; v++)
      run_op(VEC[v][33:32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);

    // directed: start held high through a sequence (R9)
    run_op(2'd2, 8'h33, 8'h44, 8'h00, 8'h9A, 1'b1);

    // directed: reset in the middle of a sequence (R10)
    @(negedge clk);
    start = 1'b1; kind = 2'd1; operand = 8'h50; x_val = 8'h01; store_val = 8'h77;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(addr == 16'h0 && !we && !done && !ld_stb && !irq_sample, "R10 mid-sequence reset",
        32'({addr, we, done, ld_stb, irq_sample}), 32'h0);
    repeat (6) begin
      @(negedge clk);
      chk(!we && !done, "R10 stays idle after reset", 32'({we, done}), 32'h0);
    end

    // back-to-back after reset still works
    run_op(2'd0, 8'h7F, 8'h80, 8'h00, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule